// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block derives the bit timing of an I2C master from a fast system clock. A byte-wide configuration word carries two divider fields. A 3-bit exponent picks a power-of-two prescale, and a 4-bit multiplier adds a further linear division by (multiplier + 1). The two stages run in cascade. Their output is a phase tick that steps a ten-step phase counter, so one SCL period spans ten ticks.

The bit engine of the master uses the phase index and the strobes that go with it. It holds SCL low during the first half of the period and releases it during the second half. It changes SDA on the phase-2 strobe and samples SDA on the phase-7 strobe. The resulting SCL rate is f_clk / (10 × base × 2^exp × (mult + 1)). The base factor is 1, or 2 when the `BASE_X2` parameter is set. Software chooses the smallest field values that keep the rate at or below the target, for example 100 kHz. Writing the configuration word clears both divider counters, so the new rate starts from a clean count.

Top module: `sclk_rate_gen`

## Requirements
- R1: The configuration word maps its fields as follows. Bits 6:3 hold the multiplier and bits 2:0 hold the exponent. Bit 7 has no effect on timing.
- R2: Consecutive `phase_tick` pulses are exactly base × 2^exp × (mult + 1) clock cycles apart. Each pulse lasts one cycle.
- R3: With `BASE_X2` = 1, the tick spacing is twice the spacing that `BASE_X2` = 0 gives for the same word.
- R4: `phase_idx` advances by one on each tick, wraps from 9 to 0, and never changes without a tick.
- R5: `scl_low` is 1 while `phase_idx` is 0 to 4 and 0 while it is 5 to 9.
- R6: `sda_change` pulses together with the tick that enters phase 2. `sda_sample` pulses together with the tick that enters phase 7. Neither pulses at any other time.
- R7: A write clears both divider counters. No tick appears in the cycle that follows the write edge. The first tick comes exactly one new period after that edge, and `phase_idx` keeps its value across the write.
- R8: After reset both fields are 0, `phase_idx` is 0, `scl_low` is 1 and no strobe is active. The first tick follows one cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 8 | Configuration word: [6:3] multiplier, [2:0] exponent, [7] unused |
| phase_tick | output | 1 | One-cycle pulse marking entry into a new phase |
| phase_idx | output | 4 | Current phase, 0 to 9 |
| scl_low | output | 1 | 1 while SCL is to be driven low |
| sda_change | output | 1 | Pulse: SDA may change now (entry into phase 2) |
| sda_sample | output | 1 | Pulse: sample SDA now (entry into phase 7) |

## Verification
A prescale or multiplier counter that holds a wrong count shows up at the ports as a tick gap different from the computed period. The fault is visible at the very next `phase_tick`, at most one period later. A counter that is not cleared on a write shows up as a wrong delay between the write and the first tick. A corrupt phase counter shows up as a skipped or out-of-range `phase_idx`, or as a strobe or SCL level that disagrees with the phase, one tick after the corruption. The bench measures both the write-to-tick delay and the tick-to-tick delay, cycle-exact, over several field settings and both base variants.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
    localparam int M_W        = 4;
    localparam int N_W        = 3;
    localparam int CFG_W      = 8;
    localparam int M_LSB      = 3;
    localparam int N_LSB      = 0;
    localparam int PHASES     = 10;
    localparam int LOW_PHASES = 5;
    localparam int CHG_PHASE  = 2;
    localparam int SMP_PHASE  = 7;
    localparam int PH_W       = $clog2(PHASES);
    localparam int PRE_W      = (1 << N_W) + 1;
    localparam int GAP_W      = PRE_W + M_W + 1;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } rate_cfg_t;

    function automatic rate_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        rate_cfg_t r;
        r.m = w[M_LSB +: M_W];
        r.n = w[N_LSB +: N_W];
        return r;
    endfunction

    function automatic logic [PH_W-1:0] next_phase(input logic [PH_W-1:0] p);
        return (p == PH_W'(PHASES - 1)) ? '0 : p + PH_W'(1);
    endfunction

    function automatic logic [GAP_W-1:0] tick_period(input rate_cfg_t c, input int base_sh);
        return (GAP_W'(c.m) + GAP_W'(1)) << (GAP_W'(c.n) + GAP_W'(base_sh));
    endfunction
endpackage

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
    import sclk_pkg::*;
#(
    parameter int BASE_X2 = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic [N_W-1:0] n,
    output logic           pre_stb
);
    logic [N_W:0]     shift;
    logic [PRE_W-1:0] limit_m1;
    logic [PRE_W-1:0] pcnt;

    generate
        if (BASE_X2 != 0) begin : g_base2
            assign shift = {1'b0, n} + (N_W+1)'(1);
        end else begin : g_base1
            assign shift = {1'b0, n};
        end
    endgenerate

    assign limit_m1 = (PRE_W'(1) << shift) - PRE_W'(1);
    assign pre_stb  = !clr && (pcnt == limit_m1);

    always_ff @(posedge clk) begin
        if (rst || clr)            pcnt <= '0;
        else if (pcnt == limit_m1) pcnt <= '0;
        else                       pcnt <= pcnt + PRE_W'(1);
    end

    // R2: prescale count stays inside the selected power-of-two window
    assert_pre_bound_R2: assert property (@(posedge clk) disable iff (rst)
        pcnt <= limit_m1);
endmodule

// File: rtl/sclk_lindiv.sv
module sclk_lindiv
    import sclk_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           pre_stb,
    input  logic [M_W-1:0] m,
    output logic           tick
);
    logic [M_W-1:0] mcnt;

    assign tick = pre_stb && (mcnt == m);

    always_ff @(posedge clk) begin
        if (rst || clr)   mcnt <= '0;
        else if (pre_stb) mcnt <= (mcnt == m) ? '0 : mcnt + M_W'(1);
    end

    // R2: linear stage never counts past the multiplier
    assert_lin_bound_R2: assert property (@(posedge clk) disable iff (rst)
        mcnt <= m);
    // R7: a cleared divider issues no tick in the clearing cycle
    assert_clr_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        clr |-> !tick);
endmodule

// File: rtl/sclk_phase_seq.sv
module sclk_phase_seq
    import sclk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    output logic            phase_tick,
    output logic [PH_W-1:0] phase_idx,
    output logic            scl_low,
    output logic            sda_change,
    output logic            sda_sample
);
    logic [PH_W-1:0] nxt;

    assign nxt = next_phase(phase_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_idx  <= '0;
            phase_tick <= 1'b0;
            scl_low    <= 1'b1;
            sda_change <= 1'b0;
            sda_sample <= 1'b0;
        end else if (adv) begin
            phase_idx  <= nxt;
            phase_tick <= 1'b1;
            scl_low    <= (nxt < PH_W'(LOW_PHASES));
            sda_change <= (nxt == PH_W'(CHG_PHASE));
            sda_sample <= (nxt == PH_W'(SMP_PHASE));
        end else begin
            phase_tick <= 1'b0;
            sda_change <= 1'b0;
            sda_sample <= 1'b0;
        end
    end

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        phase_tick |-> phase_idx == next_phase($past(phase_idx)));
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !phase_tick |-> $stable(phase_idx));
    assert_range_R4: assert property (@(posedge clk) disable iff (rst)
        phase_idx < PH_W'(PHASES));
    assert_scl_half_R5: assert property (@(posedge clk) disable iff (rst)
        scl_low == (phase_idx < PH_W'(LOW_PHASES)));
    assert_chg_R6: assert property (@(posedge clk) disable iff (rst)
        sda_change |-> (phase_tick && phase_idx == PH_W'(CHG_PHASE)));
    assert_smp_R6: assert property (@(posedge clk) disable iff (rst)
        sda_sample |-> (phase_tick && phase_idx == PH_W'(SMP_PHASE)));
    assert_excl_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sda_change, sda_sample}));
endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
    import sclk_pkg::*;
#(
    parameter int BASE_X2 = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             phase_tick,
    output logic [PH_W-1:0]  phase_idx,
    output logic             scl_low,
    output logic             sda_change,
    output logic             sda_sample
);
    localparam int BASE_SH = (BASE_X2 != 0) ? 1 : 0;

    rate_cfg_t cfg_q;
    logic      pre_stb;
    logic      div_tick;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= decode_cfg(cfg_wdata);
    end

    sclk_prescaler #(.BASE_X2(BASE_X2)) u_pre (
        .clk(clk), .rst(rst), .clr(cfg_we), .n(cfg_q.n), .pre_stb(pre_stb)
    );

    sclk_lindiv u_lin (
        .clk(clk), .rst(rst), .clr(cfg_we), .pre_stb(pre_stb),
        .m(cfg_q.m), .tick(div_tick)
    );

    sclk_phase_seq u_seq (
        .clk(clk), .rst(rst), .adv(div_tick),
        .phase_tick(phase_tick), .phase_idx(phase_idx), .scl_low(scl_low),
        .sda_change(sda_change), .sda_sample(sda_sample)
    );

    // Cycle-gap monitor on the output tick for the period checks
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] period;

    assign period = tick_period(cfg_q, BASE_SH);

    always_ff @(posedge clk) begin
        if (rst || cfg_we)   gap_q <= '0;
        else if (phase_tick) gap_q <= GAP_W'(1);
        else                 gap_q <= gap_q + GAP_W'(1);
    end

    assert_gap_exact_R2: assert property (@(posedge clk) disable iff (rst)
        phase_tick |-> gap_q == period);
    assert_gap_bound_R7: assert property (@(posedge clk) disable iff (rst)
        !phase_tick |-> gap_q < period);
endmodule

// File: tb/tb_sclk_rate_gen.sv
module tb_sclk_rate_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       phase_tick, scl_low, sda_change, sda_sample;
    logic [3:0] phase_idx;
    logic       b_tick, b_low, b_chg, b_smp;
    logic [3:0] b_idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sclk_rate_gen dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .phase_tick(phase_tick), .phase_idx(phase_idx), .scl_low(scl_low),
        .sda_change(sda_change), .sda_sample(sda_sample)
    );

    sclk_rate_gen #(.BASE_X2(1)) dut_x2 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .phase_tick(b_tick), .phase_idx(b_idx), .scl_low(b_low),
        .sda_change(b_chg), .sda_sample(b_smp)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period_of(input int m, input int n, input int base);
        return base * (1 << n) * (m + 1);
    endfunction

    // drive a write at a falling edge; return at the falling edge after the write edge
    task automatic write_cfg(input logic [7:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cycles_to_tick(input bit x2, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!(x2 ? b_tick : phase_tick) && k < 10000);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R8 idx", int'(phase_idx), 0);
        chk("R8 tick", int'(phase_tick), 0);
        chk("R8 scl_low", int'(scl_low), 1);
        chk("R8 strobes", int'(sda_change | sda_sample), 0);
        @(negedge clk);
        chk("R8 first tick", int'(phase_tick), 1);
        chk("R8 idx after first tick", int'(phase_idx), 1);
    endtask

    task automatic t_period(input int m, input int n, input bit top);
        int k;
        int idx0;
        write_cfg({top, 4'(m), 3'(n)});
        chk("R7 no tick after write", int'(phase_tick), 0);
        idx0 = int'(phase_idx);
        cycles_to_tick(1'b0, k);
        chk("R7 write to tick", k, period_of(m, n, 1));
        chk("R4 step after write", int'(phase_idx), (idx0 + 1) % 10);
        cycles_to_tick(1'b0, k);
        chk(top ? "R1 bit7 ignored" : "R2 tick gap", k, period_of(m, n, 1));
    endtask

    task automatic t_phases;
        int prev;
        write_cfg(8'h00);
        prev = int'(phase_idx);
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            chk("R2 tick every cycle", int'(phase_tick), 1);
            chk("R4 wrap step", int'(phase_idx), (prev + 1) % 10);
            chk("R5 scl half", int'(scl_low), (phase_idx < 5) ? 1 : 0);
            chk("R6 change strobe", int'(sda_change), (phase_idx == 2) ? 1 : 0);
            chk("R6 sample strobe", int'(sda_sample), (phase_idx == 7) ? 1 : 0);
            prev = int'(phase_idx);
        end
    endtask

    task automatic t_slow_hold;
        int prev;
        int k;
        write_cfg({1'b0, 4'd2, 3'd1});   // period 6
        cycles_to_tick(1'b0, k);
        prev = int'(phase_idx);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R4 hold between ticks", int'(phase_idx), prev);
            chk("R6 no strobe between ticks", int'(sda_change | sda_sample), 0);
        end
    endtask

    task automatic t_reload;
        int k;
        int idx0;
        write_cfg({1'b0, 4'd15, 3'd7});  // period 2048
        repeat (100) @(negedge clk);
        idx0 = int'(phase_idx);
        write_cfg({1'b0, 4'd1, 3'd1});   // period 4
        chk("R7 idx kept across write", int'(phase_idx), idx0);
        chk("R7 no tick after write", int'(phase_tick), 0);
        cycles_to_tick(1'b0, k);
        chk("R7 reload delay", k, 4);
    endtask

    task automatic t_base2(input int m, input int n);
        int k;
        write_cfg({1'b0, 4'(m), 3'(n)});
        cycles_to_tick(1'b1, k);
        chk("R3 x2 write to tick", k, period_of(m, n, 2));
        cycles_to_tick(1'b1, k);
        chk("R3 x2 tick gap", k, period_of(m, n, 2));
    endtask

    initial begin
        t_reset();
        t_phases();
        t_period(3, 2, 1'b0);
        t_period(15, 7, 1'b0);
        t_period(3, 2, 1'b1);
        t_period(0, 5, 1'b0);
        t_slow_hold();
        t_reload();
        t_base2(0, 0);
        t_base2(5, 3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule